// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block decides when a processor must be held in reset. It drives the enable of an open-drain reset pin from three causes. The first is a supply that is out of tolerance; after the supply recovers, the reset is stretched by a fixed hold time. The second is a push-button wired onto the same reset pin. The third is a software watchdog that has not been strobed in time. All timing is counted in pulses of a millisecond tick input. Parameters set the tick counts, so a simulation can use short intervals.

The reset pin is shared, so the block reads back the pin level through a synchronizer. Outside a reset cycle, a falling level that stays low through the debounce interval starts a push-button cycle. The block first holds reset for one hold interval. It then lets go of the pin and waits for the button to be released. After that it applies a second hold interval. The watchdog runs only while no reset cycle is in progress. A falling edge on the strobe input restarts it, and so does any write to its two-bit delay selection.

Top module: `rsv_supervisor`

## Requirements
- R1: While `pwr_good` is low, `rst_drive` is 1 from the next clock onward. The block also leaves its own reset with `rst_drive` = 1.
- R2: After `pwr_good` returns high, `rst_drive` stays 1 for HOLD_TICKS tick pulses and then falls to 0.
- R3: Outside a reset cycle, a synchronized falling edge on `pin_lvl` starts debouncing. If the level stays low for DEB_TICKS ticks, `rst_drive` is 1 for HOLD_TICKS ticks. If the level goes high earlier, no reset is produced.
- R4: When that first hold ends, `rst_drive` drops to 0 until `pin_lvl` is sampled high (button released). `rst_drive` is then 1 for a further HOLD_TICKS ticks.
- R5: The delay selection resets to 2'b11. Its encoding is 2'b00 disabled, 2'b01 WD_BASE_TICKS, 2'b10 twice that, and 2'b11 four times that. When disabled, no watchdog reset ever occurs.
- R6: The watchdog counts only while no reset cycle is active, starting from zero. A synchronized high-to-low transition on `strobe` restarts it.
- R7: When the watchdog reaches its selected period, `rst_drive` is 1 for HOLD_TICKS ticks.
- R8: A low `pwr_good` overrides every other source, including a push-button cycle in progress. The hold interval restarts from zero once `pwr_good` returns.
- R9: A write (`wd_wr` high) loads `wd_sel` and restarts the watchdog count from zero with the new period.
- R10: During a reset cycle, push-button activity and strobe edges start nothing. When the cycle ends, no extra reset follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| pwr_good | input | 1 | Supply within tolerance, synchronous to clk |
| pin_lvl | input | 1 | Sampled level of the shared reset pin (low = asserted) |
| strobe | input | 1 | Watchdog strobe; a falling edge restarts the watchdog |
| wd_wr | input | 1 | Write enable for the watchdog delay selection |
| wd_sel | input | 2 | New watchdog delay selection |
| rst_drive | output | 1 | 1 = pull the open-drain reset pin low |

## Verification
The assertions assume three things about the inputs. `tick_ms` is a single-cycle pulse. `pwr_good` is already synchronous to the clock. `pin_lvl` reads low whenever `rst_drive` is high, because the pin is open-drain. The bench derives the pin level from the drive output ORed with a modelled button, so the last assumption always holds. It also spaces ticks four cycles apart and keeps strobe pulses and button presses at least two cycles long. Each scenario gives the one-clock model and the design the same stimulus. The window lengths are chosen so that tick alignment cannot move an expected reset edge across a window boundary.

// File: rtl/rsv_pkg.sv
`timescale 1ns/1ps
package rsv_pkg;

  typedef enum logic [2:0] {
    ST_PFAIL  = 3'd0,
    ST_HOLD   = 3'd1,
    ST_IDLE   = 3'd2,
    ST_DEB    = 3'd3,
    ST_PBHOLD = 3'd4,
    ST_PBREL  = 3'd5
  } sup_state_t;

  // watchdog delay selection: 0 off, otherwise base shifted by (sel-1)
  function automatic int unsigned wd_ticks(input logic [1:0] sel, input int unsigned base);
    case (sel)
      2'b01:   wd_ticks = base;
      2'b10:   wd_ticks = base * 2;
      2'b11:   wd_ticks = base * 4;
      default: wd_ticks = 0;
    endcase
  endfunction

endpackage

// File: rtl/rsv_sync.sv
`timescale 1ns/1ps
module rsv_sync #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fall
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= RST_VAL[g];
        s2_q   <= RST_VAL[g];
        prev_q <= RST_VAL[g];
      end else begin
        s1_q   <= din[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    assign lvl[g]  = s2_q;
    assign fall[g] = prev_q & ~s2_q;
  end

endmodule

// File: rtl/rsv_watchdog.sv
`timescale 1ns/1ps
module rsv_watchdog
  import rsv_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic       kick,
  input  logic       wr,
  input  logic [1:0] wr_sel,
  output logic       expire
);

  localparam int unsigned MAX_TICKS = BASE_TICKS * 4;
  localparam int unsigned CW = $clog2(MAX_TICKS + 1);

  logic [1:0]    sel_q, sel_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] period;
  logic          enabled;

  always_comb begin
    period  = CW'(wd_ticks(sel_q, BASE_TICKS));
    enabled = (sel_q != 2'b00);
    expire  = run && enabled && tick && !kick && !wr && (cnt_q == period - 1'b1);
  end

  always_comb begin
    sel_d = wr ? wr_sel : sel_q;
    cnt_d = cnt_q;
    if (!run || kick || wr || !enabled || expire) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'b11;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  AST_WD_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != 2'b00) |-> (cnt_q < period)); // R5

endmodule

// File: rtl/rsv_supervisor.sv
`timescale 1ns/1ps
module rsv_supervisor
  import rsv_pkg::*;
#(
  parameter int unsigned HOLD_TICKS    = 250,
  parameter int unsigned DEB_TICKS     = 10,
  parameter int unsigned WD_BASE_TICKS = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       pwr_good,
  input  logic       pin_lvl,
  input  logic       strobe,
  input  logic       wd_wr,
  input  logic [1:0] wd_sel,
  output logic       rst_drive
);

  localparam int unsigned PH_MAX = (HOLD_TICKS > DEB_TICKS) ? HOLD_TICKS : DEB_TICKS;
  localparam int unsigned PH_W   = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] HOLD_LAST = PH_W'(HOLD_TICKS - 1);
  localparam logic [PH_W-1:0] DEB_LAST  = PH_W'(DEB_TICKS - 1);

  sup_state_t      st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [1:0]      sy_lvl, sy_fall;
  logic            pin_s, pin_fall, kick, wd_expire, wd_run;

  rsv_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({strobe, pin_lvl}),
    .lvl  (sy_lvl),
    .fall (sy_fall)
  );

  assign pin_s    = sy_lvl[0];
  assign pin_fall = sy_fall[0];
  assign kick     = sy_fall[1];
  assign wd_run   = (st_q == ST_IDLE);

  rsv_watchdog #(.BASE_TICKS(WD_BASE_TICKS)) u_wdog (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_ms),
    .run   (wd_run),
    .kick  (kick),
    .wr    (wd_wr),
    .wr_sel(wd_sel),
    .expire(wd_expire)
  );

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    unique case (st_q)
      ST_PFAIL: begin
        if (pwr_good) begin
          st_d = ST_HOLD;
          ph_d = '0;
        end
      end
      ST_HOLD: begin
        if (tick_ms) begin
          if (ph_q == HOLD_LAST) begin
            st_d = ST_IDLE;
            ph_d = '0;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (wd_expire) begin
          st_d = ST_HOLD;
          ph_d = '0;
        end else if (pin_fall) begin
          st_d = ST_DEB;
          ph_d = '0;
        end
      end
      ST_DEB: begin
        if (pin_s) begin
          st_d = ST_IDLE;
          ph_d = '0;
        end else if (tick_ms) begin
          if (ph_q == DEB_LAST) begin
            st_d = ST_PBHOLD;
            ph_d = '0;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      ST_PBHOLD: begin
        if (tick_ms) begin
          if (ph_q == HOLD_LAST) begin
            st_d = ST_PBREL;
            ph_d = '0;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      ST_PBREL: begin
        if (pin_s) begin
          st_d = ST_HOLD;
          ph_d = '0;
        end
      end
      default: begin
        st_d = ST_PFAIL;
        ph_d = '0;
      end
    endcase
    if (!pwr_good) begin
      st_d = ST_PFAIL;
      ph_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_PFAIL;
      ph_q <= '0;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  assign rst_drive = (st_q == ST_PFAIL) || (st_q == ST_HOLD) || (st_q == ST_PBHOLD);

  AST_PF_FORCES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> rst_drive); // R1

  AST_PF_RECOVERY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PFAIL && pwr_good) |=> (st_q == ST_HOLD && ph_q == '0)); // R2

  AST_WD_EXPIRY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> rst_drive); // R7

  AST_PB_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PBREL && !pin_s && pwr_good) |=> !rst_drive); // R4

endmodule

// File: tb/tb_rsv_supervisor.sv
`timescale 1ns/1ps
module tb_rsv_supervisor;

  localparam int HOLD = 8;
  localparam int DEB  = 3;
  localparam int BASE = 5;

  logic clk, rst_n, tick_ms, pwr_good, strobe, wd_wr, button;
  logic [1:0] wd_sel;
  logic rst_drive, pin_lvl;

  int errors = 0;
  int checks = 0;
  int rises  = 0;
  bit started = 0;
  bit prev_drv = 0;
  string phase = "R1 reset";

  assign pin_lvl = ~(rst_drive | button);

  rsv_supervisor #(.HOLD_TICKS(HOLD), .DEB_TICKS(DEB), .WD_BASE_TICKS(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .pwr_good(pwr_good),
    .pin_lvl(pin_lvl), .strobe(strobe), .wd_wr(wd_wr), .wd_sel(wd_sel),
    .rst_drive(rst_drive)
  );

  initial begin
    clk = 0;
    forever #10 clk = ~clk;
  end

  initial begin
    tick_ms = 0;
    forever begin
      repeat (3) @(negedge clk);
      tick_ms = 1;
      @(negedge clk);
      tick_ms = 0;
    end
  end

  // behavioural reference: state 0 power fail, 1 hold, 2 idle, 3 debounce,
  // 4 button hold, 5 wait release
  int m_st, m_ph, m_wd, m_sel;
  bit p1, p2, pp, s1, s2, sp;

  function automatic bit m_drive();
    return (m_st == 0) || (m_st == 1) || (m_st == 4);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_wd = 0; m_sel = 3;
      p1 = 1; p2 = 1; pp = 1; s1 = 1; s2 = 1; sp = 1;
    end else begin
      bit pfall, kk, en, ex, pin_now;
      int per, nst, nph;
      pin_now = ~(m_drive() | button);
      pfall = pp && !p2;
      kk    = sp && !s2;
      en    = (m_sel != 0);
      per   = en ? (BASE << (m_sel - 1)) : 0;
      ex    = (m_st == 2) && en && tick_ms && !kk && !wd_wr && (m_wd == per - 1);
      nst = m_st; nph = m_ph;
      if (m_st == 0) begin
        if (pwr_good) begin nst = 1; nph = 0; end
      end else if (m_st == 1 || m_st == 4) begin
        if (tick_ms) begin
          if (m_ph == HOLD - 1) begin nst = (m_st == 1) ? 2 : 5; nph = 0; end
          else nph = m_ph + 1;
        end
      end else if (m_st == 2) begin
        if (ex) begin nst = 1; nph = 0; end
        else if (pfall) begin nst = 3; nph = 0; end
      end else if (m_st == 3) begin
        if (p2) begin nst = 2; nph = 0; end
        else if (tick_ms) begin
          if (m_ph == DEB - 1) begin nst = 4; nph = 0; end
          else nph = m_ph + 1;
        end
      end else begin
        if (p2) begin nst = 1; nph = 0; end
      end
      if (!pwr_good) begin nst = 0; nph = 0; end
      if (m_st != 2 || kk || wd_wr || !en || ex) m_wd = 0;
      else if (tick_ms) m_wd = m_wd + 1;
      if (wd_wr) m_sel = wd_sel;
      m_st = nst; m_ph = nph;
      pp = p2; p2 = p1; p1 = pin_now;
      sp = s2; s2 = s1; s1 = strobe;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rst_drive !== m_drive()) begin
        errors++;
        $display("FAIL %s: rst_drive=%0b expected=%0b at %0t", phase, rst_drive, m_drive(), $time);
      end
      if (rst_drive && !prev_drv) rises++;
      prev_drv = rst_drive;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic chk(input bit exp, input string tag);
    checks++;
    if (rst_drive !== exp) begin
      errors++;
      $display("FAIL %s: rst_drive=%0b expected=%0b", tag, rst_drive, exp);
    end
  endtask

  task automatic window(input int n, input int exp, input string tag);
    rises = 0;
    cyc(n);
    checks++;
    if (rises != exp) begin
      errors++;
      $display("FAIL %s: reset pulses=%0d expected=%0d", tag, rises, exp);
    end
  endtask

  task automatic wait_level(input bit lvl, input string tag);
    int k = 0;
    while (rst_drive !== lvl && k < 300) begin
      cyc(1);
      k++;
    end
    chk(lvl, tag);
  endtask

  task automatic wr_sel(input logic [1:0] v);
    wd_sel = v;
    wd_wr  = 1;
    cyc(1);
    wd_wr  = 0;
  endtask

  initial begin
    rst_n = 0; pwr_good = 0; button = 0; strobe = 1; wd_wr = 0; wd_sel = 2'b00;
    cyc(3);
    chk(1'b1, "R1 drive during block reset");
    started = 1;
    rst_n = 1;
    cyc(20);
    chk(1'b1, "R1 drive while power low");

    phase = "R2 recovery hold";
    pwr_good = 1;
    cyc(20);
    chk(1'b1, "R2 still holding");
    cyc(30);
    chk(1'b0, "R2 released after hold");

    phase = "R7 default watchdog expiry";
    window(100, 1, "R7 single expiry reset with default period");
    wait_level(1'b0, "R7 expiry hold ends");

    phase = "R6 strobe restarts";
    rises = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(38);
      strobe = 0;
      cyc(2);
      strobe = 1;
    end
    checks++;
    if (rises != 0) begin
      errors++;
      $display("FAIL R6: reset pulses=%0d expected=0", rises);
    end

    phase = "R5 short periods";
    wr_sel(2'b01);
    window(60, 1, "R5 period of base ticks");
    wait_level(1'b0, "R5 hold ends");
    wr_sel(2'b10);
    window(50, 1, "R5 period of twice base");
    wait_level(1'b0, "R5 hold ends");
    wr_sel(2'b00);
    window(200, 0, "R5 disabled code");

    phase = "R9 write restarts";
    wr_sel(2'b11);
    cyc(60);
    wr_sel(2'b11);
    window(60, 0, "R9 rewrite restarted count");
    window(40, 1, "R9 expiry after full new period");
    wait_level(1'b0, "R9 hold ends");
    wr_sel(2'b00);

    phase = "R3 bounce";
    button = 1;
    cyc(6);
    button = 0;
    window(60, 0, "R3 short press filtered");

    phase = "R3 R4 press and release";
    button = 1;
    cyc(30);
    chk(1'b1, "R3 debounced press drives reset");
    cyc(35);
    chk(1'b0, "R4 released while button held");
    cyc(15);
    button = 0;
    cyc(10);
    chk(1'b1, "R4 second hold after release");
    wait_level(1'b0, "R4 second hold ends");

    phase = "R10 ignored during cycle";
    wr_sel(2'b01);
    wait_level(1'b1, "R10 watchdog cycle starts");
    wr_sel(2'b00);
    button = 1; strobe = 0;
    cyc(4);
    button = 0; strobe = 1;
    wait_level(1'b0, "R10 cycle ends");
    window(80, 0, "R10 no reset from activity in cycle");

    phase = "R8 power fail override";
    button = 1;
    cyc(30);
    chk(1'b1, "R8 button hold active");
    pwr_good = 0;
    cyc(10);
    chk(1'b1, "R8 power fail drives");
    pwr_good = 1;
    cyc(20);
    chk(1'b1, "R8 hold restarted from recovery");
    cyc(20);
    button = 0;
    wait_level(1'b0, "R8 hold ends");
    window(80, 0, "R8 no button cycle after override");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule